// File: doc/BRIEF.md
# Packet Receive Depacketizer

This block takes packets from a 32-bit stream sink, where the word carrying `s_tlast` closes a packet. It keeps the words in a data FIFO and queues one word count per finished packet in a separate length queue. A processor-side register port drains it. The processor reads the occupancy register to see how many fully received words are waiting. It then reads the length register, which pops the byte length of the oldest packet, and then reads the data register once per word.

Reads that do not match the packet boundaries are caught and recorded in sticky flag bits:
- a data read beyond the words granted by the last length pop (over-read),
- a length pop while granted words are still unread (under-read),
- a data read from an empty FIFO (underrun).

Writing a fixed key to the flush register empties everything and records that the flush happened. When either store is full, the stream is stalled rather than dropping words.

Top module: `rxdp_depacketizer`

## Requirements
- R1: `s_tready` is low whenever the data FIFO is full or the length queue is full. A word offered while `s_tready` is low is held by the source and later stored intact.
- R2: A read at byte offset 0x1C returns the number of stored words that belong to packets whose last word has arrived and that have not yet been popped. Words of a packet still in progress are not counted.
- R3: A read at offset 0x24 pops the oldest queued packet and returns its length in bytes (words times 4). With the queue empty it returns 0 and changes nothing.
- R4: Each read at offset 0x20 that is within the granted words returns the next stored word, in arrival order. All register reads present their value on `reg_rdata` after the clock edge that samples `reg_rd`.
- R5: Accepting a word with `s_tlast` high sets flag bit 0 (packet done).
- R6: A read at 0x20 with no granted words left, while the FIFO is not empty, sets flag bit 2 (over-read). It returns 0 and removes no word.
- R7: A length pop while granted words remain sets flag bit 1 (under-read). The unread words stay ahead of the next packet, and the grant grows by the new packet's words.
- R8: A read at 0x20 with the data FIFO empty sets flag bit 3 (underrun) and returns 0. This takes priority over bit 2.
- R9: Writing 0x000000A5 to offset 0x18 does all of the following: it discards all stored words, queued lengths and any packet in progress, it clears flag bits 0 to 3, and it sets flag bit 4 (flushed). Any other value written there changes nothing.
- R10: After reset `s_tready` is 1, all flags are 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Stream word accepted when high with `s_tvalid` |
| s_tdata | input | DATA_W | Stream word |
| s_tlast | input | 1 | Marks the final word of a packet |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | DATA_W | Register write value |
| reg_rdata | output | DATA_W | Register read value, updated one edge after `reg_rd` |
| rx_flags | output | 5 | Sticky flags: bit0 done, bit1 under-read, bit2 over-read, bit3 underrun, bit4 flushed |

## Verification
The hardest state to reach from the ports is a word held at the stream edge while the length queue is full. The bench reaches it by filling the queue with one-word packets. It then launches a further push in a parallel thread and, several cycles later, pops a length from the register side. That pop must release the word without losing it. Under-read carry-over is the other awkward case. The bench queues two packets, reads only part of the first, and pops the second length early. The remaining words of the first packet must then arrive ahead of the second packet's words.

// File: rtl/rxdp_pkg.sv
package rxdp_pkg;

   localparam int unsigned ADDR_W = 6;

   localparam logic [ADDR_W-1:0] OFS_FLUSH  = 6'h18;
   localparam logic [ADDR_W-1:0] OFS_OCCUPY = 6'h1C;
   localparam logic [ADDR_W-1:0] OFS_DATA   = 6'h20;
   localparam logic [ADDR_W-1:0] OFS_LENGTH = 6'h24;

   localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;

   localparam int unsigned FLAG_W       = 5;
   localparam int unsigned FLAG_DONE    = 0;
   localparam int unsigned FLAG_UNDER   = 1;
   localparam int unsigned FLAG_OVER    = 2;
   localparam int unsigned FLAG_EMPTYRD = 3;
   localparam int unsigned FLAG_FLUSHED = 4;

   typedef enum logic [2:0] {
      RK_IDLE,
      RK_OCC,
      RK_DATA,
      RK_LEN,
      RK_OTHER
   } rd_kind_e;

endpackage

// File: rtl/rxdp_fifo.sv
module rxdp_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic [CNT_W-1:0] count;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("rxdp_fifo: DEPTH must be at least 1");
      end
      if ((DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0)) begin : g_pow2
         always_comb begin
            wptr_nx = wptr + 1'b1;
            rptr_nx = rptr + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            wptr_nx = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            rptr_nx = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
         end
      end
   endgenerate

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign rdata = mem[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clear) mem[wptr] <= wdata;
   end

   assert_no_push_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/rxdp_ingress.sv
module rxdp_ingress #(
   parameter int unsigned DATA_DEPTH = 64
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic                              s_tvalid,
   input  logic                              s_tlast,
   input  logic                              data_full,
   input  logic                              len_full,
   output logic                              s_tready,
   output logic                              word_push,
   output logic                              len_push,
   output logic [$clog2(DATA_DEPTH+1)-1:0]   len_words
);
   localparam int unsigned CNT_W = $clog2(DATA_DEPTH + 1);

   logic [CNT_W-1:0] run;

   assign s_tready  = !data_full && !len_full && !flush;
   assign word_push = s_tvalid && s_tready;
   assign len_push  = word_push && s_tlast;
   assign len_words = run + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         run <= '0;
      end else if (word_push) begin
         run <= s_tlast ? '0 : run + 1'b1;
      end
   end

   assert_len_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      len_push |-> (len_words != '0) && (len_words <= CNT_W'(DATA_DEPTH)));

endmodule

// File: rtl/rxdp_readout.sv
module rxdp_readout
   import rxdp_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned DATA_DEPTH = 64
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_rd,
   input  logic                              reg_wr,
   input  logic [ADDR_W-1:0]                 reg_addr,
   input  logic [DATA_W-1:0]                 reg_wdata,
   input  logic [DATA_W-1:0]                 d_word,
   input  logic                              d_empty,
   input  logic [$clog2(DATA_DEPTH+1)-1:0]   l_words,
   input  logic                              l_empty,
   input  logic                              len_push,
   input  logic [$clog2(DATA_DEPTH+1)-1:0]   len_words,
   output logic                              d_pop,
   output logic                              l_pop,
   output logic                              flush,
   output logic [DATA_W-1:0]                 reg_rdata,
   output logic [FLAG_W-1:0]                 rx_flags
);
   localparam int unsigned CNT_W      = $clog2(DATA_DEPTH + 1);
   localparam int unsigned BYTE_SHIFT = $clog2(DATA_W / 8);

   rd_kind_e         kind;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] ready_cnt;
   logic             err_under, err_over, err_empty;

   always_comb begin
      kind = RK_IDLE;
      if (reg_rd) begin
         case (reg_addr)
            OFS_OCCUPY: kind = RK_OCC;
            OFS_DATA:   kind = RK_DATA;
            OFS_LENGTH: kind = RK_LEN;
            default:    kind = RK_OTHER;
         endcase
      end
   end

   assign flush     = reg_wr && (reg_addr == OFS_FLUSH) && (reg_wdata == DATA_W'(FLUSH_KEY));
   assign d_pop     = (kind == RK_DATA) && !d_empty && (remain != '0) && !flush;
   assign l_pop     = (kind == RK_LEN) && !l_empty && !flush;
   assign err_empty = (kind == RK_DATA) && d_empty;
   assign err_over  = (kind == RK_DATA) && !d_empty && (remain == '0);
   assign err_under = l_pop && (remain != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain    <= '0;
         ready_cnt <= '0;
         rx_flags  <= '0;
         reg_rdata <= '0;
      end else if (flush) begin
         remain    <= '0;
         ready_cnt <= '0;
         rx_flags  <= FLAG_W'(1) << FLAG_FLUSHED;
      end else begin
         remain    <= remain + (l_pop ? l_words : '0) - CNT_W'(d_pop);
         ready_cnt <= ready_cnt + (len_push ? len_words : '0) - CNT_W'(d_pop);
         if (len_push)  rx_flags[FLAG_DONE]    <= 1'b1;
         if (err_under) rx_flags[FLAG_UNDER]   <= 1'b1;
         if (err_over)  rx_flags[FLAG_OVER]    <= 1'b1;
         if (err_empty) rx_flags[FLAG_EMPTYRD] <= 1'b1;
         case (kind)
            RK_OCC:   reg_rdata <= DATA_W'(ready_cnt);
            RK_DATA:  reg_rdata <= d_pop ? d_word : '0;
            RK_LEN:   reg_rdata <= l_pop ? (DATA_W'(l_words) << BYTE_SHIFT) : '0;
            RK_OTHER: reg_rdata <= '0;
            default:  reg_rdata <= reg_rdata;
         endcase
      end
   end

   assert_grant_within_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= ready_cnt);

   assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      len_push |=> rx_flags[FLAG_DONE]);

   assert_over_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flags[FLAG_OVER]) |-> $past(reg_rd && (reg_addr == OFS_DATA)));

   assert_bad_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == OFS_DATA) && !flush && (d_empty || remain == '0)) |=> (reg_rdata == '0));

   assert_under_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flags[FLAG_UNDER]) |-> $past(reg_rd && (reg_addr == OFS_LENGTH)));

   assert_empty_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flags[FLAG_EMPTYRD]) |-> $past(reg_rd && (reg_addr == OFS_DATA) && d_empty));

   assert_flush_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (rx_flags == (FLAG_W'(1) << FLAG_FLUSHED)) && (ready_cnt == '0) && (remain == '0));

endmodule

// File: rtl/rxdp_depacketizer.sv
module rxdp_depacketizer
   import rxdp_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned DATA_DEPTH = 64,
   parameter int unsigned LEN_DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_tvalid,
   output logic              s_tready,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tlast,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [5:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [4:0]        rx_flags
);
   localparam int unsigned CNT_W = $clog2(DATA_DEPTH + 1);

   generate
      if ((DATA_W < 8) || ((DATA_W % 8) != 0) || (((DATA_W / 8) & ((DATA_W / 8) - 1)) != 0)) begin : g_bad_width
         $error("rxdp_depacketizer: DATA_W must be a power-of-two number of bytes");
      end
      if (DATA_DEPTH < 2) begin : g_bad_data_depth
         $error("rxdp_depacketizer: DATA_DEPTH must be at least 2");
      end
      if (LEN_DEPTH < 1) begin : g_bad_len_depth
         $error("rxdp_depacketizer: LEN_DEPTH must be at least 1");
      end
   endgenerate

   logic              flush;
   logic              word_push, len_push;
   logic [CNT_W-1:0]  len_words, l_words;
   logic              d_pop, l_pop;
   logic              d_full, d_empty, l_full, l_empty;
   logic [DATA_W-1:0] d_word;

   rxdp_ingress #(.DATA_DEPTH(DATA_DEPTH)) u_ingress (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .s_tvalid  (s_tvalid),
      .s_tlast   (s_tlast),
      .data_full (d_full),
      .len_full  (l_full),
      .s_tready  (s_tready),
      .word_push (word_push),
      .len_push  (len_push),
      .len_words (len_words)
   );

   rxdp_fifo #(.WIDTH(DATA_W), .DEPTH(DATA_DEPTH)) u_data_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (flush),
      .push  (word_push),
      .wdata (s_tdata),
      .pop   (d_pop),
      .rdata (d_word),
      .full  (d_full),
      .empty (d_empty)
   );

   rxdp_fifo #(.WIDTH(CNT_W), .DEPTH(LEN_DEPTH)) u_len_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (flush),
      .push  (len_push),
      .wdata (len_words),
      .pop   (l_pop),
      .rdata (l_words),
      .full  (l_full),
      .empty (l_empty)
   );

   rxdp_readout #(.DATA_W(DATA_W), .DATA_DEPTH(DATA_DEPTH)) u_readout (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_rd    (reg_rd),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .d_word    (d_word),
      .d_empty   (d_empty),
      .l_words   (l_words),
      .l_empty   (l_empty),
      .len_push  (len_push),
      .len_words (len_words),
      .d_pop     (d_pop),
      .l_pop     (l_pop),
      .flush     (flush),
      .reg_rdata (reg_rdata),
      .rx_flags  (rx_flags)
   );

   assert_stall_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (d_full || l_full) |-> !word_push);

endmodule

// File: tb/rxdp_depacketizer_bench.sv
module rxdp_depacketizer_bench;
   localparam int unsigned DW = 32;
   localparam int unsigned DD = 16;
   localparam int unsigned LD = 4;
   localparam logic [5:0] A_FLUSH = 6'h18, A_OCC = 6'h1C, A_DATA = 6'h20, A_LEN = 6'h24;
   localparam int NPKT = 6;
   // each entry: {word count, seed}
   localparam logic [NPKT-1:0][15:0] PKT_TAB = {16'h02_C0, 16'h07_B0, 16'h10_A0,
                                                16'h05_90, 16'h03_80, 16'h01_70};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_tvalid = 1'b0, s_tlast = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
   logic [DW-1:0] s_tdata = '0, reg_wdata = '0;
   logic [5:0]    reg_addr = '0;
   logic          s_tready;
   logic [DW-1:0] reg_rdata;
   logic [4:0]    rx_flags;
   int            n_cmp = 0, n_bad = 0;

   always #10 clk = ~clk;

   rxdp_depacketizer #(.DATA_W(DW), .DATA_DEPTH(DD), .LEN_DEPTH(LD)) u_rxdp_depacketizer (
      .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
      .s_tlast(s_tlast), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_flags(rx_flags));

   function automatic logic [31:0] wv(input logic [7:0] seed, input int k);
      return {seed, 8'h5C, 8'h00, 8'(k)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] d, input logic last);
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
      while (!s_tready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      s_tvalid = 1'b0; s_tlast = 1'b0;
   endtask

   task automatic send(input logic [7:0] seed, input int n, input logic close);
      for (int k = 0; k < n; k++) push(wv(seed, k), close && (k == n - 1));
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL all watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 tready", 32'(s_tready), 32'd1);
      check("R10 flags", 32'(rx_flags), 32'd0);
      check("R10 rdata", reg_rdata, 32'd0);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < NPKT; i++) begin
         int       n    = int'(PKT_TAB[i][15:8]);
         logic [7:0] sd = PKT_TAB[i][7:0];
         send(sd, n, 1'b1);
         check("R5 done flag", 32'(rx_flags[0]), 32'd1);
         rd(A_OCC, v);  check("R2 occupancy", v, 32'(n));
         rd(A_LEN, v);  check("R3 length", v, 32'(4 * n));
         for (int k = 0; k < n; k++) begin
            rd(A_DATA, v); check("R4 data", v, wv(sd, k));
         end
         rd(A_OCC, v);  check("R2 drained", v, 32'd0);
      end
      check("R4 no error flags", 32'(rx_flags[3:1]), 32'd0);

      // R9 flush with data stored
      send(8'h33, 2, 1'b1);
      wr(A_FLUSH, 32'h0000_00A5);
      check("R9 flags after flush", 32'(rx_flags), 32'h10);
      rd(A_OCC, v); check("R9 occupancy cleared", v, 32'd0);
      rd(A_LEN, v); check("R9 lengths cleared", v, 32'd0);

      // partial packet, over-read, empty length queue: R2 R3 R6
      send(8'h44, 2, 1'b0);
      rd(A_OCC, v); check("R2 partial not counted", v, 32'd0);
      rd(A_LEN, v); check("R3 empty queue", v, 32'd0);
      check("R3 no flag on empty queue", 32'(rx_flags), 32'h10);
      rd(A_DATA, v); check("R6 over-read value", v, 32'd0);
      check("R6 over-read flag", 32'(rx_flags), 32'h14);
      push(wv(8'h44, 2), 1'b1);
      rd(A_LEN, v); check("R3 length after close", v, 32'd12);
      for (int k = 0; k < 3; k++) begin
         rd(A_DATA, v); check("R6 no word lost", v, wv(8'h44, k));
      end
      // R8 underrun
      rd(A_DATA, v); check("R8 underrun value", v, 32'd0);
      check("R8 underrun flag", 32'(rx_flags), 32'h1D);
      // R9 wrong key ignored
      wr(A_FLUSH, 32'h0000_005A);
      check("R9 wrong key ignored", 32'(rx_flags), 32'h1D);

      // R7 under-read carry-over
      wr(A_FLUSH, 32'h0000_00A5);
      send(8'h55, 3, 1'b1);
      send(8'h66, 2, 1'b1);
      rd(A_LEN, v);  check("R7 first length", v, 32'd12);
      rd(A_DATA, v); check("R7 first word", v, wv(8'h55, 0));
      rd(A_OCC, v);  check("R2 occupancy mid packet", v, 32'd4);
      rd(A_LEN, v);  check("R7 second length", v, 32'd8);
      check("R7 under-read flag", 32'(rx_flags[1]), 32'd1);
      for (int k = 1; k < 3; k++) begin
         rd(A_DATA, v); check("R7 tail first", v, wv(8'h55, k));
      end
      for (int k = 0; k < 2; k++) begin
         rd(A_DATA, v); check("R7 next packet", v, wv(8'h66, k));
      end

      // R1 length queue full, held word released
      wr(A_FLUSH, 32'h0000_00A5);
      for (int k = 0; k < 4; k++) push(32'h100 + 32'(k), 1'b1);
      check("R1 stall on length queue full", 32'(s_tready), 32'd0);
      fork
         push(32'h0000_CAFE, 1'b1);
         begin
            repeat (4) @(negedge clk);
            check("R1 still stalled", 32'(s_tready), 32'd0);
            rd(A_LEN, v); check("R1 length while stalled", v, 32'd4);
         end
      join
      rd(A_DATA, v); check("R1 first word", v, 32'h100);
      for (int k = 1; k < 5; k++) begin
         rd(A_LEN, v);  check("R1 queued length", v, 32'd4);
         rd(A_DATA, v); check("R1 held word kept", v, (k == 4) ? 32'h0000_CAFE : 32'h100 + 32'(k));
      end

      // R1 data FIFO full
      send(8'h77, 16, 1'b1);
      check("R1 stall on data full", 32'(s_tready), 32'd0);
      rd(A_LEN, v);  check("R3 max length", v, 32'd64);
      rd(A_DATA, v); check("R4 word after full", v, wv(8'h77, 0));
      check("R1 ready after pop", 32'(s_tready), 32'd1);

      summary();
      $finish;
   end
endmodule